// File: doc/BRIEF.md
# Exclusive-Access Reservation Monitor

This block lets several cores share one word-addressed memory and perform optimistic read-modify-write sequences without locking each other out. A core opens a sequence with a reserving load. The load returns the word and arms a reservation that covers the whole 64-byte line holding that word. The core later closes the sequence with a conditional store. That store writes memory and reports success only if the core's reservation survived, meaning no other core wrote anywhere in the line in between. If the reservation was lost, the store is discarded and the core is told it failed, so software can retry.

Every core has its own request and response channel, and every request is accepted in the cycle it is presented. Requests that arrive in the same cycle are ordered by core index: lower indices act first. Loads see the effect of writes from lower-indexed cores in that cycle, and reservations react to those writes as if the requests had arrived one after another.

Top module: `resv_monitor`

## Requirements
- R1: Each request is accepted in the cycle it is presented, with no stall. Exactly one response appears on the same core's channel in the following cycle. Operation codes on the 2-bit op field are 0 = load, 1 = reserving load, 2 = store, 3 = conditional store.
- R2: A load or reserving load returns the 32-bit word at the request address. Address bits [1:0] are ignored. A store writes its data to that word. Store responses carry data 0 and fail flag 0.
- R3: A conditional store succeeds when the issuing core holds a valid reservation on the same 64-byte line and no other core has written that line since the reservation was made. On success it writes memory and returns fail flag 0.
- R4: A conditional store that does not succeed returns fail flag 1 and leaves memory unchanged. The fail flag is 1 only for failed conditional stores.
- R5: A plain store or a successful conditional store by another core to a reserved line cancels that reservation. A write to a different line does not cancel it.
- R6: Reservations cover the whole 64-byte line (address bits [ADDR_W-1:6]). A write by another core to any word of the line cancels the reservation.
- R7: A core holds at most one reservation. A new reserving load replaces the previous one, including its line.
- R8: A conditional store clears the issuing core's reservation whether it succeeds or fails. A second conditional store without a new reserving load fails.
- R9: A conditional store with no reserving load before it fails.
- R10: Requests in the same cycle take effect in ascending core index order. A write from a lower core cancels a higher core's reservation on that line before the higher core's conditional store is judged. A write from a higher core cancels a reservation taken by a lower core in that cycle. A load returns data written by a lower core in that cycle but not data written by a higher core.
- R11: After reset all memory words read 0, no core holds a reservation, and no response is valid.
- R12: A core's own plain store does not cancel its own reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_CORES | Request present, one bit per core |
| req_op | input | 2*NUM_CORES | Operation code per core (2 bits each, core 0 in the low bits) |
| req_addr | input | ADDR_W*NUM_CORES | Byte address per core |
| req_wdata | input | DATA_W*NUM_CORES | Write data per core |
| rsp_valid | output | NUM_CORES | Response present, one cycle after the request |
| rsp_rdata | output | DATA_W*NUM_CORES | Load data per core, 0 for stores |
| rsp_fail | output | NUM_CORES | 1 when a conditional store failed |

## Verification
The assertions assume that req_valid is held low while rst_n is low, so that a request issued during reset never has to produce a response. They also assume that op, address and data are stable whenever valid is high in a sampled cycle. The bench drives every request on the falling edge and holds all valid bits at zero until reset has been released. Requests are staged per cycle and pushed into the expectation queue in ascending core order, which matches the same-cycle ordering the block applies. The bench also checks the response cycle of every item, so that a late or duplicated response is caught.

// File: rtl/resv_mon_pkg.sv
// Package: shared operation encoding for the reservation monitor.
package resv_mon_pkg;
    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_LOADX  = 2'd1,
        OP_STORE  = 2'd2,
        OP_STOREX = 2'd3
    } mem_op_e;
endpackage

// File: rtl/rmon_order.sv
// rmon_order: purely combinational resolution of one cycle of requests.
// It walks the cores in ascending index order. For each core it decides
// whether a conditional store succeeds, whether the core writes memory,
// and what the core's reservation valid bit becomes.
// Assumes: line indices are already extracted from the byte addresses.
module rmon_order
    import resv_mon_pkg::*;
#(
    parameter int NC = 4,
    parameter int LW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NC-1:0]          vld,
    input  logic [NC-1:0][1:0]     op,
    input  logic [NC-1:0][LW-1:0]  line,
    input  logic [NC-1:0]          res_vld,
    input  logic [NC-1:0][LW-1:0]  res_line,
    output logic [NC-1:0]          wr_en,
    output logic [NC-1:0]          sc_ok,
    output logic [NC-1:0]          res_next
);

    logic [NC-1:0] wr_c;
    logic [NC-1:0] ok_c;
    logic [NC-1:0] nxt_c;

    // Serialized pass: a conditional store sees every earlier core's write.
    always_comb begin
        wr_c = '0;
        ok_c = '0;
        for (int i = 0; i < NC; i++) begin
            logic early;
            early = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (wr_c[j] && (line[j] == line[i])) early = 1'b1;
            end
            ok_c[i] = vld[i] && (op[i] == OP_STOREX) && res_vld[i]
                      && (res_line[i] == line[i]) && !early;
            wr_c[i] = (vld[i] && (op[i] == OP_STORE)) || ok_c[i];
        end
    end

    // Next reservation state: arm, clear, or cancel by a foreign write.
    always_comb begin
        nxt_c = '0;
        for (int i = 0; i < NC; i++) begin
            logic later;
            logic foreign;
            later   = 1'b0;
            foreign = 1'b0;
            for (int j = 0; j < NC; j++) begin
                if ((j > i) && wr_c[j] && (line[j] == line[i])) later = 1'b1;
                if ((j != i) && wr_c[j] && (line[j] == res_line[i])) foreign = 1'b1;
            end
            if (vld[i] && (op[i] == OP_LOADX))
                nxt_c[i] = !later;
            else if (vld[i] && (op[i] == OP_STOREX))
                nxt_c[i] = 1'b0;
            else
                nxt_c[i] = res_vld[i] && !foreign;
        end
    end

    assign wr_en    = wr_c;
    assign sc_ok    = ok_c;
    assign res_next = nxt_c;

    // R10: no two cores win a conditional store on the same line in one cycle.
    for (genvar a = 0; a < NC; a++) begin : g_pa
        for (genvar b = a + 1; b < NC; b++) begin : g_pb
            a_r10_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
                !(sc_ok[a] && sc_ok[b] && (line[a] == line[b])));
        end
    end

endmodule

// File: rtl/rmon_resv.sv
// rmon_resv: holds one reservation (valid bit and line index) per core.
// Assumes: the order stage already computed the next valid bit. The line
// is reloaded only by a reserving load.
module rmon_resv #(
    parameter int NC = 4,
    parameter int LW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NC-1:0]          take,
    input  logic [NC-1:0][LW-1:0]  line_in,
    input  logic [NC-1:0]          res_next,
    output logic [NC-1:0]          res_vld,
    output logic [NC-1:0][LW-1:0]  res_line
);

    for (genvar g = 0; g < NC; g++) begin : g_core
        // Per-core reservation register update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_vld[g]  <= 1'b0;
                res_line[g] <= '0;
            end else begin
                res_vld[g] <= res_next[g];
                if (take[g]) res_line[g] <= line_in[g];
            end
        end

        // R7: a reserving load always retargets the reservation line.
        a_r7_line_replaced: assert property (@(posedge clk) disable iff (!rst_n)
            take[g] |=> (res_line[g] == $past(line_in[g])));
    end

endmodule

// File: rtl/rmon_store.sv
// rmon_store: word storage with one write and one read port per core.
// Writes land in ascending core order, so the highest index wins on a
// shared word. A read returns the stored word, or the latest write from
// a lower-indexed core in the same cycle.
// Assumes: word indices span the full storage depth.
module rmon_store #(
    parameter int NC = 4,
    parameter int DW = 32,
    parameter int WW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NC-1:0]          wr_en,
    input  logic [NC-1:0][WW-1:0]  word,
    input  logic [NC-1:0][DW-1:0]  wdata,
    output logic [NC-1:0][DW-1:0]  rdata
);

    localparam int DEPTH = 1 << WW;

    logic [DW-1:0] mem [DEPTH];

    // Ordered write port update and zeroing on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else begin
            for (int j = 0; j < NC; j++) begin
                if (wr_en[j]) mem[word[j]] <= wdata[j];
            end
        end
    end

    // Read with forwarding from lower-indexed writers in the same cycle.
    always_comb begin
        for (int i = 0; i < NC; i++) begin
            rdata[i] = mem[word[i]];
            for (int j = 0; j < i; j++) begin
                if (wr_en[j] && (word[j] == word[i])) rdata[i] = wdata[j];
            end
        end
    end

    // R4: with no write enabled, a probed word keeps its value.
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == '0) |=> (mem[0] == $past(mem[0])));

endmodule

// File: rtl/resv_monitor.sv
// resv_monitor: top of the exclusive-access reservation monitor.
// Splits the flat per-core ports, resolves one cycle of requests in core
// order, updates the storage and reservations, and registers one response
// per request.
// Assumes: req_valid is low during reset, and byte addresses are
// interpreted as word index plus byte offset.
module resv_monitor
    import resv_mon_pkg::*;
#(
    parameter int NUM_CORES  = 4,
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CORES-1:0]          req_valid,
    input  logic [2*NUM_CORES-1:0]        req_op,
    input  logic [ADDR_W*NUM_CORES-1:0]   req_addr,
    input  logic [DATA_W*NUM_CORES-1:0]   req_wdata,
    output logic [NUM_CORES-1:0]          rsp_valid,
    output logic [DATA_W*NUM_CORES-1:0]   rsp_rdata,
    output logic [NUM_CORES-1:0]          rsp_fail
);

    localparam int NC       = NUM_CORES;
    localparam int BYTE_LSB = $clog2(DATA_W / 8);
    localparam int LINE_LSB = $clog2(LINE_BYTES);
    localparam int WORD_W   = ADDR_W - BYTE_LSB;
    localparam int LINE_W   = ADDR_W - LINE_LSB;

    logic [NC-1:0][1:0]        op_w;
    logic [NC-1:0][WORD_W-1:0] word_w;
    logic [NC-1:0][LINE_W-1:0] line_w;
    logic [NC-1:0][DATA_W-1:0] wdata_w;
    logic [NC-1:0][DATA_W-1:0] rd_w;
    logic [NC-1:0]             take_w;
    logic [NC-1:0]             wr_en;
    logic [NC-1:0]             sc_ok;
    logic [NC-1:0]             res_next;
    logic [NC-1:0]             res_vld;
    logic [NC-1:0][LINE_W-1:0] res_line;
    logic [NC-1:0]             rv_q;
    logic [NC-1:0][DATA_W-1:0] rd_q;
    logic [NC-1:0]             fail_q;

    for (genvar g = 0; g < NC; g++) begin : g_split
        assign op_w[g]    = req_op[2*g +: 2];
        assign word_w[g]  = req_addr[ADDR_W*g + BYTE_LSB +: WORD_W];
        assign line_w[g]  = req_addr[ADDR_W*g + LINE_LSB +: LINE_W];
        assign wdata_w[g] = req_wdata[DATA_W*g +: DATA_W];
        assign take_w[g]  = req_valid[g] && (op_w[g] == OP_LOADX);
        assign rsp_rdata[DATA_W*g +: DATA_W] = rd_q[g];
    end

    rmon_order #(.NC(NC), .LW(LINE_W)) u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld      (req_valid),
        .op       (op_w),
        .line     (line_w),
        .res_vld  (res_vld),
        .res_line (res_line),
        .wr_en    (wr_en),
        .sc_ok    (sc_ok),
        .res_next (res_next)
    );

    rmon_resv #(.NC(NC), .LW(LINE_W)) u_resv (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take_w),
        .line_in  (line_w),
        .res_next (res_next),
        .res_vld  (res_vld),
        .res_line (res_line)
    );

    rmon_store #(.NC(NC), .DW(DATA_W), .WW(WORD_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .word  (word_w),
        .wdata (wdata_w),
        .rdata (rd_w)
    );

    // Response register: one response per accepted request, next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv_q   <= '0;
            rd_q   <= '0;
            fail_q <= '0;
        end else begin
            for (int c = 0; c < NC; c++) begin
                rv_q[c]   <= req_valid[c];
                rd_q[c]   <= (req_valid[c] && ((op_w[c] == OP_LOAD) || (op_w[c] == OP_LOADX)))
                             ? rd_w[c] : '0;
                fail_q[c] <= req_valid[c] && (op_w[c] == OP_STOREX) && !sc_ok[c];
            end
        end
    end

    assign rsp_valid = rv_q;
    assign rsp_fail  = fail_q;

    for (genvar g = 0; g < NC; g++) begin : g_chk
        // R1: a request gets its response one cycle later.
        a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[g] |=> rsp_valid[g]);
        a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid[g] |=> !rsp_valid[g]);
        // R4: a fail flag only ever answers a conditional store.
        a_r4_fail_only_sc: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_fail[g] |-> $past(req_valid[g] && (op_w[g] == OP_STOREX)));
        // R9: a conditional store without a reservation reports failure.
        a_r9_noresv_fails: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[g] && (op_w[g] == OP_STOREX) && !res_vld[g]) |=> rsp_fail[g]);
        // R8: a conditional store leaves its core without a reservation.
        a_r8_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[g] && (op_w[g] == OP_STOREX)) |=> !res_vld[g]);
    end

endmodule

// File: tb/resv_monitor_tb.sv
// Scoreboard bench: put() stages per-core requests with their expected
// responses; go() drives one cycle and queues expectations; a monitor on
// the falling edge pops and compares each response as it arrives.
module resv_monitor_tb;
    import resv_mon_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int AW = 10;
    localparam int DW = 32;

    typedef struct {
        int          core;
        logic [31:0] data;
        logic        fail;
        int          cyc;
        string       rq;
    } exp_t;

    logic               clk;
    logic               rst_n;
    logic [NC-1:0]      req_valid;
    logic [2*NC-1:0]    req_op;
    logic [AW*NC-1:0]   req_addr;
    logic [DW*NC-1:0]   req_wdata;
    logic [NC-1:0]      rsp_valid;
    logic [DW*NC-1:0]   rsp_rdata;
    logic [NC-1:0]      rsp_fail;

    int    checks = 0;
    int    errors = 0;
    int    cyc_cnt = 0;
    bit    done = 0;
    exp_t  q[$];

    logic [NC-1:0]        st_v;
    logic [NC-1:0][1:0]   st_op;
    logic [NC-1:0][AW-1:0] st_addr;
    logic [NC-1:0][DW-1:0] st_wd;
    logic [NC-1:0][DW-1:0] st_ed;
    logic [NC-1:0]        st_ef;
    string                st_rq [NC];

    resv_monitor #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW), .LINE_BYTES(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_fail(rsp_fail)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic put(input int c, input logic [1:0] op, input int addr,
                       input logic [31:0] wd, input logic [31:0] ed,
                       input logic ef, input string rq);
        st_v[c] = 1'b1; st_op[c] = op; st_addr[c] = AW'(addr);
        st_wd[c] = wd; st_ed[c] = ed; st_ef[c] = ef; st_rq[c] = rq;
    endtask

    task automatic go();
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            req_valid[c]            = st_v[c];
            req_op[2*c +: 2]        = st_op[c];
            req_addr[AW*c +: AW]    = st_addr[c];
            req_wdata[DW*c +: DW]   = st_wd[c];
            if (st_v[c]) q.push_back('{c, st_ed[c], st_ef[c], cyc_cnt + 1, st_rq[c]});
        end
        st_v = '0; st_op = '0; st_addr = '0; st_wd = '0; st_ed = '0; st_ef = '0;
    endtask

    // Monitor: pop and compare each response as it appears.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < NC; c++) begin
                if (rsp_valid[c]) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R1", "unexpected response core", c, 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        chk(e.core == c && e.cyc == cyc_cnt, "R1", "response core/cycle",
                            c, e.core);
                        chk(rsp_rdata[DW*c +: DW] == e.data && rsp_fail[c] == e.fail, e.rq,
                            (rsp_fail[c] != e.fail) ? "fail flag" : "data",
                            (rsp_fail[c] != e.fail) ? 32'(rsp_fail[c]) : rsp_rdata[DW*c +: DW],
                            (rsp_fail[c] != e.fail) ? 32'(e.fail) : e.data);
                    end
                end
            end
            if (q.size() != 0 && q[0].cyc < cyc_cnt) begin
                chk(1'b0, "R1", "missing response core", q[0].core, q[0].cyc);
                void'(q.pop_front());
            end
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0;
        st_v = '0; st_op = '0; st_addr = '0; st_wd = '0; st_ed = '0; st_ef = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(rsp_valid == '0, "R11", "rsp_valid after reset", 32'(rsp_valid), 0);

        // R11: memory reads zero after reset.
        put(0, OP_LOAD, 'h040, 0, 0, 0, "R11"); go();
        // R2: store then load, byte offset ignored.
        put(0, OP_STORE, 'h010, 32'hA1, 0, 0, "R2"); go();
        put(1, OP_LOAD, 'h010, 0, 32'hA1, 0, "R2");
        put(2, OP_LOAD, 'h013, 0, 32'hA1, 0, "R2"); go();
        // R3: reserve and conditionally store.
        put(0, OP_LOADX, 'h100, 0, 0, 0, "R3"); go();
        put(0, OP_STOREX, 'h100, 32'd55, 0, 0, "R3"); go();
        put(1, OP_LOAD, 'h100, 0, 32'd55, 0, "R3"); go();
        // R9/R4: conditional store with no reservation fails and writes nothing.
        put(2, OP_STOREX, 'h200, 32'd77, 0, 1, "R9"); go();
        put(3, OP_LOAD, 'h200, 0, 0, 0, "R4"); go();
        // R6/R5: write to another word of the reserved line cancels it.
        put(0, OP_LOADX, 'h080, 0, 0, 0, "R6"); go();
        put(1, OP_STORE, 'h084, 32'd9, 0, 0, "R6"); go();
        put(0, OP_STOREX, 'h080, 32'd1, 0, 1, "R6"); go();
        put(2, OP_LOAD, 'h080, 0, 0, 0, "R4");
        put(3, OP_LOAD, 'h084, 0, 32'd9, 0, "R6"); go();
        // R5: write to a different line leaves the reservation alone.
        put(0, OP_LOADX, 'h0C0, 0, 0, 0, "R5"); go();
        put(1, OP_STORE, 'h3C0, 32'd3, 0, 0, "R5"); go();
        put(0, OP_STOREX, 'h0C0, 32'd4, 0, 0, "R5"); go();
        put(1, OP_LOAD, 'h0C0, 0, 32'd4, 0, "R5"); go();
        // R5: successful conditional store by another core cancels.
        put(0, OP_LOADX, 'h140, 0, 0, 0, "R5");
        put(1, OP_LOADX, 'h140, 0, 0, 0, "R5"); go();
        put(1, OP_STOREX, 'h140, 32'd8, 0, 0, "R5"); go();
        put(0, OP_STOREX, 'h140, 32'd9, 0, 1, "R5"); go();
        put(2, OP_LOAD, 'h140, 0, 32'd8, 0, "R4"); go();
        // R7: a new reserving load replaces the old one.
        put(0, OP_LOADX, 'h180, 0, 0, 0, "R7"); go();
        put(0, OP_LOADX, 'h1C0, 0, 0, 0, "R7"); go();
        put(1, OP_STORE, 'h180, 32'd1, 0, 0, "R7"); go();
        put(0, OP_STOREX, 'h1C0, 32'd6, 0, 0, "R7"); go();
        put(0, OP_LOADX, 'h180, 0, 32'd1, 0, "R7"); go();
        put(0, OP_LOADX, 'h1C0, 0, 32'd6, 0, "R7"); go();
        put(0, OP_STOREX, 'h180, 32'd2, 0, 1, "R7"); go();
        put(1, OP_LOAD, 'h180, 0, 32'd1, 0, "R7"); go();
        // R8: a conditional store consumes the reservation.
        put(3, OP_LOADX, 'h240, 0, 0, 0, "R8"); go();
        put(3, OP_STOREX, 'h240, 32'd5, 0, 0, "R8"); go();
        put(3, OP_STOREX, 'h240, 32'd6, 0, 1, "R8"); go();
        put(3, OP_LOAD, 'h240, 0, 32'd5, 0, "R8"); go();
        // R12: own plain store keeps own reservation.
        put(2, OP_LOADX, 'h280, 0, 0, 0, "R12"); go();
        put(2, OP_STORE, 'h284, 32'd7, 0, 0, "R12"); go();
        put(2, OP_STOREX, 'h280, 32'd2, 0, 0, "R12"); go();
        put(3, OP_LOAD, 'h280, 0, 32'd2, 0, "R12"); go();
        // R10: same-cycle conditional stores, lower core wins.
        put(0, OP_LOADX, 'h2C0, 0, 0, 0, "R10");
        put(1, OP_LOADX, 'h2C0, 0, 0, 0, "R10"); go();
        put(0, OP_STOREX, 'h2C0, 32'd11, 0, 0, "R10");
        put(1, OP_STOREX, 'h2C0, 32'd12, 0, 1, "R10"); go();
        put(2, OP_LOAD, 'h2C0, 0, 32'd11, 0, "R10"); go();
        // R10: higher core's write after a lower core's reserving load cancels it.
        put(0, OP_LOADX, 'h300, 0, 0, 0, "R10");
        put(3, OP_STORE, 'h304, 32'd1, 0, 0, "R10"); go();
        put(0, OP_STOREX, 'h300, 32'd2, 0, 1, "R10"); go();
        put(1, OP_LOAD, 'h300, 0, 0, 0, "R10"); go();
        // R10: forwarding from lower writer only.
        put(0, OP_STORE, 'h340, 32'h33, 0, 0, "R10");
        put(1, OP_LOAD, 'h340, 0, 32'h33, 0, "R10"); go();
        put(1, OP_LOAD, 'h380, 0, 0, 0, "R10");
        put(2, OP_STORE, 'h380, 32'd5, 0, 0, "R10"); go();
        put(0, OP_LOAD, 'h380, 0, 32'd5, 0, "R10"); go();
        // R1: all cores at once, all answered next cycle.
        put(0, OP_LOAD, 'h010, 0, 32'hA1, 0, "R1");
        put(1, OP_LOAD, 'h100, 0, 32'd55, 0, "R1");
        put(2, OP_STORE, 'h3C4, 32'd1, 0, 0, "R1");
        put(3, OP_STOREX, 'h3C8, 32'd1, 0, 1, "R1"); go();
        go(); go(); go();

        chk(q.size() == 0, "R1", "outstanding expectations", q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule